// File: doc/BRIEF.md
# System Status Flag Word

This block gathers scattered system condition signals into one 32-bit read-only word on a simple memory-mapped bus. Each bit follows its own capture rule. Some bits show the live level of a pin after synchronisation, in some cases inverted. Some are sticky event flags that an edge sets and a write to a dedicated strobe address clears. One 4-bit field holds a display panel identity, taken from the panel data lines while the display is disabled and frozen once it is enabled.

Asynchronous pins pass through a synchroniser with a parameterised number of stages, two by default. Edge detection compares the synchronised level with a registered copy of it. The standby indication, the display enable and the serial-port transmitter busy signal are already synchronous and are used as they arrive. A write to one of three strobe addresses clears the matching sticky flags. If a set event and a clear strobe fall in the same cycle, the set wins. The read port is combinational: when the status address is selected it returns the word, and otherwise it returns zero.

Top module: `sys_status_word`

## Requirements
- R1: `rd_data_o` equals the status word in the same cycle when `rd_sel_i` is 1 and `rd_addr_i` equals the status address (default 0x10). It is zero in every other case.
- R2: A write to the status address has no effect. After such a write, sticky bits 3, 12 and 13 keep their previous values.
- R3: Bit 0 is the inverse of the synchronised media-changed pin. Bit 1 is the inverse of the synchronised external-power pin, which is active low. Bit 2 is the synchronised wakeup level. A pin change shows on these bits after two clock edges.
- R4: Bits 8, 9 and 10 are the synchronised live levels of the modem inputs CTS, DSR and DCD. Bit 11 follows `uart_tx_busy_i` in the same cycle, with no synchroniser.
- R5: Bit 3 is set by a rising edge of the synchronised wakeup level that occurs while `standby_i` is 1. A wakeup edge while `standby_i` is 0 leaves bit 3 unchanged.
- R6: A write to the halt strobe address (default 0x20) clears bit 3. A write to the standby strobe address (default 0x24) also clears bit 3.
- R7: While `panel_en_i` is 0, bits 7:4 follow the synchronised panel data lines, with bit 4 taken from line 0. While `panel_en_i` is 1, bits 7:4 hold the last value loaded.
- R8: Bit 12 is set by a rising edge of the synchronised new-battery pin. Bit 13 is set by a falling edge of the synchronised reset-button pin, which is active low.
- R9: A write to the flag-clear address (default 0x28) clears bits 12 and 13. Halt and standby strobes leave bits 12 and 13 unchanged.
- R10: If a set event and a clearing strobe for the same sticky bit arrive in the same cycle, the bit ends set.
- R11: Bits 31:30 return the `HW_VERSION` parameter. Bits 29:14 read zero.
- R12: While `rst_n` is low, the sticky bits, the panel field and all synchroniser stages are zero. The word then reads `HW_VERSION`<<30 | 0x3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| media_chg_i | input | 1 | Media-changed pin, asynchronous |
| extpwr_n_i | input | 1 | External-power pin, active low, asynchronous |
| wake_i | input | 1 | Wakeup pin, asynchronous |
| standby_i | input | 1 | System is in standby, synchronous |
| btn_rst_n_i | input | 1 | Reset-button pin, active low, asynchronous |
| newbat_i | input | 1 | New-battery pin, asynchronous |
| panel_d_i | input | 4 | Display panel data lines, asynchronous |
| panel_en_i | input | 1 | Display enable, synchronous |
| cts_i | input | 1 | Modem CTS input, asynchronous |
| dsr_i | input | 1 | Modem DSR input, asynchronous |
| dcd_i | input | 1 | Modem DCD input, asynchronous |
| uart_tx_busy_i | input | 1 | Serial transmitter busy, synchronous |
| wr_en_i | input | 1 | Bus write strobe |
| wr_addr_i | input | ADDR_W | Bus write address |
| rd_sel_i | input | 1 | Bus read select |
| rd_addr_i | input | ADDR_W | Bus read address |
| rd_data_o | output | 32 | Read data |

## Verification
The bench targets a clear strobe that lands in the same cycle as a set event. A design that lets the clear win loses the event and reads 0 there. It checks that halt and standby strobes clear only the wakeup flag and that a write to the status address clears nothing. A decoder that shares addresses would wipe the battery or button flags. It changes the panel lines while the display is enabled, which a design that keeps loading the field would expose. It also drives a wakeup edge outside standby, where an unqualified detector would set bit 3. A cycle model of the two-stage synchroniser and the edge registers checks every field on every clock. Any extra or missing pipeline stage therefore shows up as a one-cycle skew.

// File: rtl/sysstat_pkg.sv
package sysstat_pkg;

   localparam int SW_W      = 32;
   localparam int ID_W      = 4;
   localparam int VER_W     = 2;

   localparam int B_MEDIA   = 0;
   localparam int B_EXTPWR  = 1;
   localparam int B_WAKELVL = 2;
   localparam int B_WAKEFLG = 3;
   localparam int B_ID_LO   = 4;
   localparam int B_CTS     = 8;
   localparam int B_DSR     = 9;
   localparam int B_DCD     = 10;
   localparam int B_TXBUSY  = 11;
   localparam int B_NEWBAT  = 12;
   localparam int B_BTNRST  = 13;
   localparam int B_VER_LO  = 30;

   // bundle of asynchronous pins that share one synchroniser
   typedef struct packed {
      logic [ID_W-1:0] panel;
      logic            btn_n;
      logic            newbat;
      logic            dcd;
      logic            dsr;
      logic            cts;
      logic            wake;
      logic            extpwr_n;
      logic            media;
   } pins_t;

   localparam int PINS_W = $bits(pins_t);

endpackage

// File: rtl/ss_sync.sv
module ss_sync #(
   parameter int W      = 1,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   logic [STAGES-1:0][W-1:0] stg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg <= '0;
      else        stg <= {stg[STAGES-2:0], d};
   end

   assign q = stg[STAGES-1];

endmodule

// File: rtl/ss_edge_flag.sv
module ss_edge_flag #(
   parameter bit RISING = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic lvl,
   input  logic qual,
   input  logic clr,
   output logic flag,
   output logic set_evt
);

   logic prev;
   logic hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev <= 1'b0;
      else        prev <= lvl;
   end

   generate
      if (RISING) begin : g_rise
         assign hit = lvl & ~prev;
      end else begin : g_fall
         assign hit = ~lvl & prev;
      end
   endgenerate

   assign set_evt = hit & qual;

   // a set event outranks a clear strobe in the same cycle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       flag <= 1'b0;
      else if (set_evt) flag <= 1'b1;
      else if (clr)     flag <= 1'b0;
   end

endmodule

// File: rtl/ss_hold_latch.sv
module ss_hold_latch #(
   parameter int W = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         hold,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     q <= '0;
      else if (!hold) q <= d;
   end

endmodule

// File: rtl/sys_status_word.sv
module sys_status_word
   import sysstat_pkg::*;
#(
   parameter int              ADDR_W      = 8,
   parameter int              SYNC_STAGES = 2,
   parameter int unsigned     ADDR_STATUS = 'h10,
   parameter int unsigned     ADDR_HALT   = 'h20,
   parameter int unsigned     ADDR_STDBY  = 'h24,
   parameter int unsigned     ADDR_FCLR   = 'h28,
   parameter logic [VER_W-1:0] HW_VERSION = 2'b01
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              media_chg_i,
   input  logic              extpwr_n_i,
   input  logic              wake_i,
   input  logic              standby_i,
   input  logic              btn_rst_n_i,
   input  logic              newbat_i,
   input  logic [ID_W-1:0]   panel_d_i,
   input  logic              panel_en_i,
   input  logic              cts_i,
   input  logic              dsr_i,
   input  logic              dcd_i,
   input  logic              uart_tx_busy_i,
   input  logic              wr_en_i,
   input  logic [ADDR_W-1:0] wr_addr_i,
   input  logic              rd_sel_i,
   input  logic [ADDR_W-1:0] rd_addr_i,
   output logic [SW_W-1:0]   rd_data_o
);

   localparam logic [ADDR_W-1:0] ADR_STAT  = ADDR_W'(ADDR_STATUS);
   localparam logic [ADDR_W-1:0] ADR_HALT  = ADDR_W'(ADDR_HALT);
   localparam logic [ADDR_W-1:0] ADR_STDBY = ADDR_W'(ADDR_STDBY);
   localparam logic [ADDR_W-1:0] ADR_FCLR  = ADDR_W'(ADDR_FCLR);

   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
      if (ADDR_W < 2 || ADDR_W > 32) begin : g_bad_aw
         $error("ADDR_W out of range");
      end
      if (ADR_STAT == ADR_HALT || ADR_STAT == ADR_STDBY || ADR_STAT == ADR_FCLR ||
          ADR_HALT == ADR_STDBY || ADR_HALT == ADR_FCLR || ADR_STDBY == ADR_FCLR) begin : g_bad_map
         $error("strobe and status addresses must be distinct");
      end
   endgenerate

   // synchronise all asynchronous pins as one bundle
   pins_t               raw;
   pins_t               syn;
   logic [PINS_W-1:0]   syn_vec;

   always_comb begin
      raw          = '0;
      raw.media    = media_chg_i;
      raw.extpwr_n = extpwr_n_i;
      raw.wake     = wake_i;
      raw.cts      = cts_i;
      raw.dsr      = dsr_i;
      raw.dcd      = dcd_i;
      raw.newbat   = newbat_i;
      raw.btn_n    = btn_rst_n_i;
      raw.panel    = panel_d_i;
   end

   ss_sync #(.W(PINS_W), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (raw),
      .q     (syn_vec)
   );

   assign syn = pins_t'(syn_vec);

   // clear strobes decoded from bus writes
   logic stb_halt, stb_stdby, stb_fclr;
   assign stb_halt  = wr_en_i && (wr_addr_i == ADR_HALT);
   assign stb_stdby = wr_en_i && (wr_addr_i == ADR_STDBY);
   assign stb_fclr  = wr_en_i && (wr_addr_i == ADR_FCLR);

   logic wake_flag, wake_set;
   logic nb_flag,   nb_set;
   logic btn_flag,  btn_set;

   ss_edge_flag #(.RISING(1'b1)) u_wake (
      .clk     (clk),
      .rst_n   (rst_n),
      .lvl     (syn.wake),
      .qual    (standby_i),
      .clr     (stb_halt | stb_stdby),
      .flag    (wake_flag),
      .set_evt (wake_set)
   );

   ss_edge_flag #(.RISING(1'b1)) u_newbat (
      .clk     (clk),
      .rst_n   (rst_n),
      .lvl     (syn.newbat),
      .qual    (1'b1),
      .clr     (stb_fclr),
      .flag    (nb_flag),
      .set_evt (nb_set)
   );

   ss_edge_flag #(.RISING(1'b0)) u_button (
      .clk     (clk),
      .rst_n   (rst_n),
      .lvl     (syn.btn_n),
      .qual    (1'b1),
      .clr     (stb_fclr),
      .flag    (btn_flag),
      .set_evt (btn_set)
   );

   logic [ID_W-1:0] panel_id;

   ss_hold_latch #(.W(ID_W)) u_panel (
      .clk   (clk),
      .rst_n (rst_n),
      .hold  (panel_en_i),
      .d     (syn.panel),
      .q     (panel_id)
   );

   logic [SW_W-1:0] status_word;

   always_comb begin
      status_word                              = '0;
      status_word[B_MEDIA]                     = ~syn.media;
      status_word[B_EXTPWR]                    = ~syn.extpwr_n;
      status_word[B_WAKELVL]                   = syn.wake;
      status_word[B_WAKEFLG]                   = wake_flag;
      status_word[B_ID_LO +: ID_W]             = panel_id;
      status_word[B_CTS]                       = syn.cts;
      status_word[B_DSR]                       = syn.dsr;
      status_word[B_DCD]                       = syn.dcd;
      status_word[B_TXBUSY]                    = uart_tx_busy_i;
      status_word[B_NEWBAT]                    = nb_flag;
      status_word[B_BTNRST]                    = btn_flag;
      status_word[B_VER_LO +: VER_W]           = HW_VERSION;
   end

   assign rd_data_o = (rd_sel_i && (rd_addr_i == ADR_STAT)) ? status_word : '0;

endmodule

// File: rtl/sys_status_chk.sv
module sys_status_chk #(
   parameter int                ADDR_W    = 8,
   parameter logic [ADDR_W-1:0] A_STAT    = '0,
   parameter logic [ADDR_W-1:0] A_HALT    = '0,
   parameter logic [ADDR_W-1:0] A_STDBY   = '0,
   parameter logic [ADDR_W-1:0] A_FCLR    = '0
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic [ADDR_W-1:0] wr_addr,
   input logic              hold_id,
   input logic              wake_set,
   input logic              nb_set,
   input logic              btn_set,
   input logic [31:0]       word
);

   a_r2_status_write_inert: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == A_STAT && !wake_set && !nb_set && !btn_set)
      |=> ($stable(word[3]) && $stable(word[13:12])));

   a_r6_wake_cleared: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && (wr_addr == A_HALT || wr_addr == A_STDBY) && !wake_set) |=> !word[3]);

   a_r9_flags_cleared: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == A_FCLR && !nb_set && !btn_set) |=> (word[13:12] == 2'b00));

   a_r10_wake_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      wake_set |=> word[3]);

   a_r10_newbat_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      nb_set |=> word[12]);

   a_r10_button_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      btn_set |=> word[13]);

   a_r7_panel_held: assert property (@(posedge clk) disable iff (!rst_n)
      hold_id |=> $stable(word[7:4]));

   a_r8_newbat_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (word[12] && !(wr_en && wr_addr == A_FCLR)) |=> word[12]);

endmodule

bind sys_status_word sys_status_chk #(
   .ADDR_W  (ADDR_W),
   .A_STAT  (ADR_STAT),
   .A_HALT  (ADR_HALT),
   .A_STDBY (ADR_STDBY),
   .A_FCLR  (ADR_FCLR)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .wr_en    (wr_en_i),
   .wr_addr  (wr_addr_i),
   .hold_id  (panel_en_i),
   .wake_set (wake_set),
   .nb_set   (nb_set),
   .btn_set  (btn_set),
   .word     (status_word)
);

// File: tb/tb_sys_status_word.sv
module tb_sys_status_word;

   localparam logic [1:0] TB_VER = 2'b10;
   localparam logic [7:0] A_STAT = 8'h10;
   localparam logic [7:0] A_HALT = 8'h20;
   localparam logic [7:0] A_STBY = 8'h24;
   localparam logic [7:0] A_FCLR = 8'h28;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   // pin vector: 0 media,1 extpwr_n,2 wake,3 cts,4 dsr,5 dcd,6 newbat,7 btn_n,11:8 panel
   logic [11:0] pv = 12'h080;
   logic        standby = 1'b0;
   logic        panel_en = 1'b0;
   logic        busy = 1'b0;
   logic        wr_en = 1'b0;
   logic [7:0]  wr_addr = 8'h00;
   logic        rd_sel = 1'b1;
   logic [7:0]  rd_addr = A_STAT;
   logic [31:0] rd_data;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #4 clk = ~clk;

   sys_status_word #(.HW_VERSION(TB_VER)) dut (
      .clk            (clk),
      .rst_n          (rst_n),
      .media_chg_i    (pv[0]),
      .extpwr_n_i     (pv[1]),
      .wake_i         (pv[2]),
      .standby_i      (standby),
      .btn_rst_n_i    (pv[7]),
      .newbat_i       (pv[6]),
      .panel_d_i      (pv[11:8]),
      .panel_en_i     (panel_en),
      .cts_i          (pv[3]),
      .dsr_i          (pv[4]),
      .dcd_i          (pv[5]),
      .uart_tx_busy_i (busy),
      .wr_en_i        (wr_en),
      .wr_addr_i      (wr_addr),
      .rd_sel_i       (rd_sel),
      .rd_addr_i      (rd_addr),
      .rd_data_o      (rd_data)
   );

   task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s got=%h exp=%h", tag, got, exp);
      end
   endtask

   // reference model: history of sampled pins plus sticky state
   logic [11:0] h0, h1, h2;
   logic        m_wake, m_nb, m_btn;
   logic [3:0]  m_id;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         h0 <= '0; h1 <= '0; h2 <= '0;
         m_wake <= 1'b0; m_nb <= 1'b0; m_btn <= 1'b0; m_id <= '0;
      end else begin
         if (h1[2] && !h2[2] && standby) m_wake <= 1'b1;
         else if (wr_en && (wr_addr == A_HALT || wr_addr == A_STBY)) m_wake <= 1'b0;
         if (h1[6] && !h2[6]) m_nb <= 1'b1;
         else if (wr_en && wr_addr == A_FCLR) m_nb <= 1'b0;
         if (!h1[7] && h2[7]) m_btn <= 1'b1;
         else if (wr_en && wr_addr == A_FCLR) m_btn <= 1'b0;
         if (!panel_en) m_id <= h1[11:8];
         h0 <= pv; h1 <= h0; h2 <= h1;
      end
   end

   always @(posedge clk) begin
      #2;
      if (!done) begin
         if (!(rd_sel && rd_addr == A_STAT)) begin
            chk("R1 read gated", rd_data, 32'h0);
         end else begin
            chk("R3 direct bits", {29'h0, rd_data[2:0]}, {29'h0, h1[2], ~h1[1], ~h1[0]});
            chk("R5 R6 R10 wake flag", {31'h0, rd_data[3]}, {31'h0, m_wake});
            chk("R7 panel id", {28'h0, rd_data[7:4]}, {28'h0, m_id});
            chk("R4 modem and busy", {28'h0, rd_data[11:8]}, {28'h0, busy, h1[5], h1[4], h1[3]});
            chk("R8 R9 R10 sticky pair", {30'h0, rd_data[13:12]}, {30'h0, m_btn, m_nb});
            chk("R11 upper bits", {14'h0, rd_data[31:14]}, {14'h0, TB_VER, 16'h0});
         end
      end
   end

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(input logic [7:0] a);
      wr_en = 1'b1; wr_addr = a;
      @(negedge clk);
      wr_en = 1'b0; wr_addr = 8'h00;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_chk++; n_fail++;
         $display("FAIL watchdog got=timeout exp=completion");
         $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      logic [31:0] lf;
      step(4);
      chk("R12 reset word", rd_data, {TB_VER, 30'h3});
      rst_n = 1'b1;
      step(6);

      // R5: wakeup edge outside standby does nothing
      pv[2] = 1'b1; step(5);
      chk("R5 no set outside standby", {31'h0, rd_data[3]}, 32'h0);
      chk("R3 wake level", {31'h0, rd_data[2]}, 32'h1);
      pv[2] = 1'b0; step(4);
      standby = 1'b1; pv[2] = 1'b1; step(5);
      chk("R5 set in standby", {31'h0, rd_data[3]}, 32'h1);
      wr(A_STAT);
      chk("R2 status write keeps wake", {31'h0, rd_data[3]}, 32'h1);
      wr(A_HALT);
      chk("R6 halt clears", {31'h0, rd_data[3]}, 32'h0);
      pv[2] = 1'b0; step(4); pv[2] = 1'b1; step(5);
      wr(A_STBY);
      chk("R6 standby clears", {31'h0, rd_data[3]}, 32'h0);

      // R10: wake edge meets halt strobe in the same cycle
      pv[2] = 1'b0; step(4);
      pv[2] = 1'b1; step(2);
      wr(A_HALT);
      chk("R10 wake set beats halt", {31'h0, rd_data[3]}, 32'h1);
      pv[2] = 1'b0; standby = 1'b0; wr(A_HALT);

      // R8, R9
      pv[6] = 1'b1; step(5);
      chk("R8 newbat rise", {30'h0, rd_data[13:12]}, 32'h1);
      pv[7] = 1'b0; step(5);
      chk("R8 button fall", {30'h0, rd_data[13:12]}, 32'h3);
      pv[7] = 1'b1; step(3);
      wr(A_HALT); wr(A_STBY);
      chk("R9 halt and standby keep pair", {30'h0, rd_data[13:12]}, 32'h3);
      wr(A_STAT);
      chk("R2 status write keeps pair", {30'h0, rd_data[13:12]}, 32'h3);
      wr(A_FCLR);
      chk("R9 flag clear", {30'h0, rd_data[13:12]}, 32'h0);
      pv[6] = 1'b0; step(4);
      pv[6] = 1'b1; step(2);
      wr(A_FCLR);
      chk("R10 newbat set beats clear", {31'h0, rd_data[12]}, 32'h1);
      wr(A_FCLR);

      // R7
      pv[11:8] = 4'hA; step(5);
      chk("R7 tracks while disabled", {28'h0, rd_data[7:4]}, 32'hA);
      panel_en = 1'b1; pv[11:8] = 4'h5; step(5);
      chk("R7 holds while enabled", {28'h0, rd_data[7:4]}, 32'hA);
      panel_en = 1'b0; step(2);
      chk("R7 reloads after disable", {28'h0, rd_data[7:4]}, 32'h5);

      // R4, R3
      pv[3] = 1'b1; pv[4] = 1'b0; pv[5] = 1'b1; busy = 1'b1; pv[1] = 1'b1; pv[0] = 1'b1; step(3);
      chk("R4 modem levels", {28'h0, rd_data[11:8]}, 32'hD);
      chk("R3 inverted pins", {30'h0, rd_data[1:0]}, 32'h0);
      busy = 1'b0; #1;
      chk("R4 busy same cycle", {31'h0, rd_data[11]}, 32'h0);
      step(1);

      // R1, R11
      rd_addr = A_HALT; #1;
      chk("R1 other address reads zero", rd_data, 32'h0);
      rd_addr = A_STAT; rd_sel = 1'b0; #1;
      chk("R1 deselected reads zero", rd_data, 32'h0);
      rd_sel = 1'b1; #1;
      chk("R11 version", {30'h0, rd_data[31:30]}, {30'h0, TB_VER});
      step(1);

      // pseudo-random phase, checked each cycle by the model
      lf = 32'h1ACE_B00C;
      for (int i = 0; i < 4000; i++) begin
         lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
         if (lf[3:1] == 3'd0) pv[lf[7:4] % 12] = ~pv[lf[7:4] % 12];
         wr_en = (lf[10:8] == 3'd0);
         case (lf[13:11])
            3'd0: wr_addr = A_STAT;
            3'd1: wr_addr = A_HALT;
            3'd2: wr_addr = A_STBY;
            3'd3: wr_addr = A_FCLR;
            default: wr_addr = 8'h33;
         endcase
         if (lf[18:16] == 3'd0) standby = ~standby;
         if (lf[24:21] == 4'd0) panel_en = ~panel_en;
         busy = lf[26];
         rd_sel = (lf[29:27] != 3'd0);
         rd_addr = lf[30] ? A_HALT : A_STAT;
         if (lf[31] && lf[15]) rd_addr = A_STAT;
         step(1);
      end
      wr_en = 1'b0;
      step(2);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

endmodule